// File: doc/BRIEF.md
# Immediate-Operand Execution Unit

This unit is the register-and-execute stage of a small 16-bit coprocessor. It takes one instruction that is already decoded: an opcode, a register index and an 8-bit immediate field. It performs the instruction on a bank of eight 16-bit general registers. Supported work covers logical shifts by a 4-bit count, byte-wide immediate arithmetic and loads, a low-byte compare that only sets flags, jump-and-link through a register, and a software trigger that raises one of 128 interrupt-request lines.

A full 16-bit constant is built from two byte-half instructions. A constant load issues the low-half load first and the high-half load second. A 16-bit immediate add issues the low-byte add first and the high-byte add second. The program counter steps by two on every executed instruction, except jump-and-link, which swaps the counter with a register. Two combinational read ports give the surrounding logic a view of any register.

Top module: `imm_exec_unit`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every register reads 0, `pc_q` is 0, all four flags are 0 and `irq_pulse` is 0. Reset is asynchronous.
- R2: Register 0 always reads 0 on both read ports, and writes to it are discarded. Flags still follow the computed result.
- R3: Opcodes LSL (1) and LSR (2) shift the register by `op_imm[3:0]` and write the result back. C is the last bit shifted out, V is 0, and N and Z follow the result. A count of 0 leaves the register unchanged and clears C.
- R4: ADDL (3) adds the zero-extended immediate, and ADDH (4) adds the immediate shifted left by 8. C is the carry out of bit 15 and V is the signed overflow. N is bit 15 of the result and Z is set when the result is zero.
- R5: SUBL (5) subtracts the zero-extended immediate. C is the borrow out of bit 15, V is the signed overflow, and N and Z follow the result.
- R6: LDL (6) replaces bits 7:0 and LDH (7) replaces bits 15:8, leaving the other byte unchanged. N and Z follow the 16-bit result, V is cleared and C is kept.
- R7: CMPL (8) subtracts the immediate from the register's low byte. It sets N to bit 7 of the difference, Z when the byte difference is zero, C to the borrow and V to the 8-bit signed overflow. The register is not changed.
- R8: JAL (9) loads `pc_q` with the register value and writes the old `pc_q` plus 2 into that register. Flags are unchanged. With register 0, `pc_q` becomes 0.
- R9: Every executed instruction other than JAL advances `pc_q` by 2. A cycle with `op_valid` low changes no register, no flag and not `pc_q`.
- R10: SIF (10) sets bit k of `irq_pulse` for exactly the one cycle after the instruction, where k is bits 7:0 of the named register. Values of k of 128 or more raise nothing. At most one bit is set at a time.
- R11: Opcode values 0 and 11 to 15 change no register and no flag, but still advance `pc_q` by 2.
- R12: LDL followed by LDH on the same register loads a 16-bit constant. ADDL followed by ADDH adds a 16-bit constant, including the carry out of the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Executes the presented instruction this cycle |
| op_code | input | 4 | Decoded opcode (values in R3 to R11) |
| op_rd | input | 3 | Register operated on |
| op_imm | input | 8 | Immediate field; bits 3:0 are the shift count |
| rd_addr_a | input | 3 | Read port A register index |
| rd_data_a | output | 16 | Read port A data |
| rd_addr_b | input | 3 | Read port B register index |
| rd_data_b | output | 16 | Read port B data |
| pc_q | output | 16 | Program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / borrow / shifted-out flag |
| irq_pulse | output | 128 | Software interrupt-request pulses |

## Verification
Two software triggers can arrive on consecutive cycles. When that happens, the falling edge of one pulse and the rising edge of the next fall on the same clock edge. The bench provokes this by issuing triggers back to back: a valid channel followed by an out-of-range channel, then two valid channels. After each edge it checks that only the newest channel's bit is set, or no bit at all for the out-of-range case. Jump-and-link is the other same-cycle case: it reads a register for the counter and writes the link into the same register. The bench judges it by checking both `pc_q` and the register afterwards.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_LSL  = 4'd1,
      OP_LSR  = 4'd2,
      OP_ADDL = 4'd3,
      OP_ADDH = 4'd4,
      OP_SUBL = 4'd5,
      OP_LDL  = 4'd6,
      OP_LDH  = 4'd7,
      OP_CMPL = 4'd8,
      OP_JAL  = 4'd9,
      OP_SIF  = 4'd10
   } opcode_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

endpackage

// File: rtl/iex_shifter.sv
module iex_shifter #(
   parameter int DATA_W  = 16,
   parameter int SHAMT_W = 4,
   parameter bit BARREL  = 1'b1
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   output logic [DATA_W-1:0]  shl_q,
   output logic               shl_c,
   output logic [DATA_W-1:0]  shr_q,
   output logic               shr_c
);
   // one guard bit catches the last bit pushed out on either side
   localparam int EW = DATA_W + 1;

   logic [EW-1:0] lw;
   logic [EW-1:0] rw;

   generate
      if (BARREL) begin : g_barrel
         logic [EW-1:0] l_st [SHAMT_W+1];
         logic [EW-1:0] r_st [SHAMT_W+1];
         assign l_st[0] = {1'b0, din};
         assign r_st[0] = {din, 1'b0};
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            assign l_st[k+1] = amt[k] ? (l_st[k] << (1 << k)) : l_st[k];
            assign r_st[k+1] = amt[k] ? (r_st[k] >> (1 << k)) : r_st[k];
         end
         assign lw = l_st[SHAMT_W];
         assign rw = r_st[SHAMT_W];
      end else begin : g_flat
         assign lw = {1'b0, din} << amt;
         assign rw = {din, 1'b0} >> amt;
      end
   endgenerate

   assign shl_q = lw[DATA_W-1:0];
   assign shl_c = lw[DATA_W];
   assign shr_q = rw[DATA_W:1];
   assign shr_c = rw[0];

endmodule

// File: rtl/iex_alu.sv
module iex_alu
   import imm_exec_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int IMM_W   = 8,
   parameter int SHAMT_W = 4,
   parameter bit BARREL  = 1'b1
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] src,
   input  logic [IMM_W-1:0]  imm,
   input  flags_t            fl_in,
   output logic [DATA_W-1:0] res,
   output flags_t            fl_out,
   output logic              wr_req
);
   localparam int MSB  = DATA_W - 1;
   localparam int BMSB = IMM_W - 1;

   logic [DATA_W-1:0] shl_q, shr_q;
   logic              shl_c, shr_c;

   iex_shifter #(
      .DATA_W (DATA_W),
      .SHAMT_W(SHAMT_W),
      .BARREL (BARREL)
   ) u_shift (
      .din  (src),
      .amt  (imm[SHAMT_W-1:0]),
      .shl_q(shl_q),
      .shl_c(shl_c),
      .shr_q(shr_q),
      .shr_c(shr_c)
   );

   logic [DATA_W-1:0] lo_ext, hi_ext, add_src;
   logic [DATA_W:0]   sum, diff;
   logic [IMM_W:0]    bdiff;
   logic              upd_nz;

   assign lo_ext  = DATA_W'(imm);
   assign hi_ext  = lo_ext << IMM_W;
   assign add_src = (op == OP_ADDH) ? hi_ext : lo_ext;
   assign sum     = {1'b0, src} + {1'b0, add_src};
   assign diff    = {1'b0, src} - {1'b0, lo_ext};
   assign bdiff   = {1'b0, src[BMSB:0]} - {1'b0, imm};

   always_comb begin
      res    = src;
      fl_out = fl_in;
      wr_req = 1'b0;
      upd_nz = 1'b0;
      unique case (op)
         OP_LSL: begin
            res      = shl_q;
            fl_out.c = shl_c;
            fl_out.v = 1'b0;
            wr_req   = 1'b1;
            upd_nz   = 1'b1;
         end
         OP_LSR: begin
            res      = shr_q;
            fl_out.c = shr_c;
            fl_out.v = 1'b0;
            wr_req   = 1'b1;
            upd_nz   = 1'b1;
         end
         OP_ADDL, OP_ADDH: begin
            res      = sum[MSB:0];
            fl_out.c = sum[DATA_W];
            fl_out.v = ~(src[MSB] ^ add_src[MSB]) & (src[MSB] ^ sum[MSB]);
            wr_req   = 1'b1;
            upd_nz   = 1'b1;
         end
         OP_SUBL: begin
            res      = diff[MSB:0];
            fl_out.c = diff[DATA_W];
            fl_out.v = (src[MSB] ^ lo_ext[MSB]) & (src[MSB] ^ diff[MSB]);
            wr_req   = 1'b1;
            upd_nz   = 1'b1;
         end
         OP_LDL: begin
            res      = {src[MSB:IMM_W], imm};
            fl_out.v = 1'b0;
            wr_req   = 1'b1;
            upd_nz   = 1'b1;
         end
         OP_LDH: begin
            res      = {imm, src[BMSB:0]};
            fl_out.v = 1'b0;
            wr_req   = 1'b1;
            upd_nz   = 1'b1;
         end
         OP_CMPL: begin
            fl_out.n = bdiff[BMSB];
            fl_out.z = (bdiff[BMSB:0] == '0);
            fl_out.c = bdiff[IMM_W];
            fl_out.v = (src[BMSB] ^ imm[BMSB]) & (src[BMSB] ^ bdiff[BMSB]);
         end
         default: ;
      endcase
      if (upd_nz) begin
         fl_out.n = res[MSB];
         fl_out.z = (res == '0);
      end
   end

endmodule

// File: rtl/iex_regfile.sv
module iex_regfile #(
   parameter int DATA_W = 16,
   parameter int NREGS  = 8,
   localparam int AW    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [AW-1:0]     raddr_b,
   output logic [DATA_W-1:0] rdata_b,
   input  logic [AW-1:0]     raddr_x,
   output logic [DATA_W-1:0] rdata_x
);
   logic [DATA_W-1:0] rows [NREGS];

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         logic [DATA_W-1:0] q;
         if (i == 0) begin : g_zero
            assign q = '0;
         end else begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (we && (waddr == AW'(i)))
                  q <= wdata;
            end
         end
         assign rows[i] = q;
      end
   endgenerate

   assign rdata_a = rows[raddr_a];
   assign rdata_b = rows[raddr_b];
   assign rdata_x = rows[raddr_x];

endmodule

// File: rtl/iex_irq_pulse.sv
module iex_irq_pulse #(
   parameter int IRQ_LINES = 128,
   parameter int CHAN_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire,
   input  logic [CHAN_W-1:0]    chan,
   output logic [IRQ_LINES-1:0] pulse
);
   logic [IRQ_LINES-1:0] hit;

   generate
      for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
         assign hit[i] = (chan == CHAN_W'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pulse <= '0;
      else
         pulse <= fire ? hit : '0;
   end

endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
   import imm_exec_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int IMM_W        = 8,
   parameter int SHAMT_W      = 4,
   parameter int NREGS        = 8,
   parameter int IRQ_LINES    = 128,
   parameter int PC_STEP      = 2,
   parameter int RESET_PC     = 0,
   parameter bit BARREL_SHIFT = 1'b1,
   localparam int AW          = $clog2(NREGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [3:0]           op_code,
   input  logic [AW-1:0]        op_rd,
   input  logic [IMM_W-1:0]     op_imm,
   input  logic [AW-1:0]        rd_addr_a,
   output logic [DATA_W-1:0]    rd_data_a,
   input  logic [AW-1:0]        rd_addr_b,
   output logic [DATA_W-1:0]    rd_data_b,
   output logic [DATA_W-1:0]    pc_q,
   output logic                 flag_n,
   output logic                 flag_z,
   output logic                 flag_v,
   output logic                 flag_c,
   output logic [IRQ_LINES-1:0] irq_pulse
);
   // elaboration-time parameter checks
   if (DATA_W != 2 * IMM_W) begin : g_bad_width
      $error("imm_exec_unit: DATA_W must be twice IMM_W");
   end
   if (SHAMT_W > IMM_W || (1 << SHAMT_W) > DATA_W) begin : g_bad_shamt
      $error("imm_exec_unit: SHAMT_W does not fit the immediate or the word");
   end
   if (IRQ_LINES < 1 || IRQ_LINES > (1 << IMM_W)) begin : g_bad_irq
      $error("imm_exec_unit: IRQ_LINES must lie in 1 .. 2**IMM_W");
   end
   if (NREGS < 2) begin : g_bad_regs
      $error("imm_exec_unit: at least two registers are needed");
   end

   opcode_e           opc;
   flags_t            flags_q, alu_fl;
   logic [DATA_W-1:0] x_data, alu_res, link, wr_data;
   logic              alu_wr, is_jal, is_sif, rf_we;

   assign opc    = opcode_e'(op_code);
   assign is_jal = op_valid && (opc == OP_JAL);
   assign is_sif = op_valid && (opc == OP_SIF);
   assign link   = pc_q + DATA_W'(PC_STEP);

   iex_regfile #(
      .DATA_W(DATA_W),
      .NREGS (NREGS)
   ) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rf_we),
      .waddr  (op_rd),
      .wdata  (wr_data),
      .raddr_a(rd_addr_a),
      .rdata_a(rd_data_a),
      .raddr_b(rd_addr_b),
      .rdata_b(rd_data_b),
      .raddr_x(op_rd),
      .rdata_x(x_data)
   );

   iex_alu #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .SHAMT_W(SHAMT_W),
      .BARREL (BARREL_SHIFT)
   ) u_alu (
      .op    (opc),
      .src   (x_data),
      .imm   (op_imm),
      .fl_in (flags_q),
      .res   (alu_res),
      .fl_out(alu_fl),
      .wr_req(alu_wr)
   );

   assign rf_we   = op_valid && (alu_wr || (opc == OP_JAL));
   assign wr_data = (opc == OP_JAL) ? link : alu_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= DATA_W'(RESET_PC);
         flags_q <= '0;
      end else if (op_valid) begin
         pc_q    <= is_jal ? x_data : link;
         flags_q <= alu_fl;
      end
   end

   iex_irq_pulse #(
      .IRQ_LINES(IRQ_LINES),
      .CHAN_W   (IMM_W)
   ) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (is_sif),
      .chan (x_data[IMM_W-1:0]),
      .pulse(irq_pulse)
   );

   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
   assign flag_v = flags_q.v;
   assign flag_c = flags_q.c;

endmodule

// File: rtl/imm_exec_unit_chk.sv
module imm_exec_unit_chk
   import imm_exec_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int AW        = 3,
   parameter int IRQ_LINES = 128,
   parameter int PC_STEP   = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic [3:0]           op_code,
   input logic [AW-1:0]        op_rd,
   input logic [AW-1:0]        rd_addr_a,
   input logic [DATA_W-1:0]    rd_data_a,
   input logic [DATA_W-1:0]    pc_q,
   input logic                 flag_n,
   input logic                 flag_z,
   input logic                 flag_v,
   input logic                 flag_c,
   input logic [IRQ_LINES-1:0] irq_pulse
);

   // R2
   r0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   // R10
   irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_pulse));

   // R10
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse != '0) |-> $past(op_valid && (op_code == OP_SIF)));

   // R10
   irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_pulse != '0) && !(op_valid && (op_code == OP_SIF))) |=> (irq_pulse == '0));

   // R9
   idle_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(pc_q));

   // R9
   idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable({flag_n, flag_z, flag_v, flag_c}));

   // R9
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code != OP_JAL)) |=> (pc_q == DATA_W'($past(pc_q) + PC_STEP)));

   // R7
   cmpl_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_CMPL) && (rd_addr_a == op_rd))
      |=> ((rd_addr_a != $past(rd_addr_a)) || (rd_data_a == $past(rd_data_a))));

endmodule

bind imm_exec_unit imm_exec_unit_chk #(
   .DATA_W   (DATA_W),
   .AW       (AW),
   .IRQ_LINES(IRQ_LINES),
   .PC_STEP  (PC_STEP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .op_rd    (op_rd),
   .rd_addr_a(rd_addr_a),
   .rd_data_a(rd_data_a),
   .pc_q     (pc_q),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_v   (flag_v),
   .flag_c   (flag_c),
   .irq_pulse(irq_pulse)
);

// File: tb/imm_exec_unit_bench.sv
module imm_exec_unit_bench;
   import imm_exec_pkg::*;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [3:0]   op_code = 4'd0;
   logic [2:0]   op_rd = 3'd0;
   logic [7:0]   op_imm = 8'd0;
   logic [2:0]   rd_addr_a = 3'd0;
   logic [2:0]   rd_addr_b = 3'd0;
   logic [15:0]  rd_data_a, rd_data_b, pc_q;
   logic         flag_n, flag_z, flag_v, flag_c;
   logic [127:0] irq_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   imm_exec_unit u_imm_exec_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_code  (op_code),
      .op_rd    (op_rd),
      .op_imm   (op_imm),
      .rd_addr_a(rd_addr_a),
      .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b),
      .rd_data_b(rd_data_b),
      .pc_q     (pc_q),
      .flag_n   (flag_n),
      .flag_z   (flag_z),
      .flag_v   (flag_v),
      .flag_c   (flag_c),
      .irq_pulse(irq_pulse)
   );

   // entry: {opcode[34:31], reg[30:28], imm[27:20], expected reg[19:4], expected NZVC[3:0]}
   localparam int NV = 27;
   localparam logic [34:0] VEC [NV] = '{
      {OP_LDL,  3'd1, 8'h34, 16'h0034, 4'b0000},  // R6, R12
      {OP_LDH,  3'd1, 8'h12, 16'h1234, 4'b0000},  // R6, R12
      {OP_ADDL, 3'd1, 8'h78, 16'h12AC, 4'b0000},  // R4, R12
      {OP_ADDH, 3'd1, 8'h56, 16'h68AC, 4'b0000},  // R4, R12
      {OP_LDH,  3'd2, 8'h7F, 16'h7F00, 4'b0000},
      {OP_LDL,  3'd2, 8'hFF, 16'h7FFF, 4'b0000},
      {OP_ADDL, 3'd2, 8'h01, 16'h8000, 4'b1010},  // R4 signed overflow
      {OP_SUBL, 3'd2, 8'h01, 16'h7FFF, 4'b0010},  // R5 signed overflow
      {OP_LDL,  3'd3, 8'h05, 16'h0005, 4'b0000},
      {OP_SUBL, 3'd3, 8'h06, 16'hFFFF, 4'b1001},  // R5 borrow
      {OP_ADDL, 3'd3, 8'h01, 16'h0000, 4'b0101},  // R4 carry, zero
      {OP_LDH,  3'd4, 8'h80, 16'h8000, 4'b1001},  // R6 keeps C
      {OP_LSR,  3'd4, 8'h0F, 16'h0001, 4'b0000},  // R3
      {OP_LSL,  3'd4, 8'h0F, 16'h8000, 4'b1000},  // R3
      {OP_LSL,  3'd4, 8'h01, 16'h0000, 4'b0101},  // R3 C from bit 15
      {OP_LDL,  3'd5, 8'hB5, 16'h00B5, 4'b0001},
      {OP_LSR,  3'd5, 8'h03, 16'h0016, 4'b0001},  // R3 C from bit 2
      {OP_LSL,  3'd5, 8'h00, 16'h0016, 4'b0000},  // R3 count zero
      {OP_CMPL, 3'd5, 8'h16, 16'h0016, 4'b0100},  // R7 equal
      {OP_CMPL, 3'd5, 8'h17, 16'h0016, 4'b1001},  // R7 below
      {OP_CMPL, 3'd1, 8'hAC, 16'h68AC, 4'b0100},  // R7 high byte ignored
      {OP_LDL,  3'd6, 8'h80, 16'h0080, 4'b0000},
      {OP_CMPL, 3'd6, 8'h01, 16'h0080, 4'b0010},  // R7 byte overflow
      {OP_LDL,  3'd0, 8'hFF, 16'h0000, 4'b0000},  // R2
      {OP_ADDL, 3'd0, 8'h05, 16'h0000, 4'b0000},  // R2
      {OP_ADDH, 3'd2, 8'h80, 16'hFFFF, 4'b1000},  // R4
      {OP_ADDH, 3'd2, 8'h01, 16'h00FF, 4'b0001}   // R4 carry out of high byte
   };

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [2:0] rd, input logic [7:0] imm);
      @(negedge clk);
      op_valid  = 1'b1;
      op_code   = op;
      op_rd     = rd;
      op_imm    = imm;
      rd_addr_a = rd;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      op_valid  = 1'b0;
      op_code   = OP_LDL;
      op_rd     = 3'd1;
      op_imm    = 8'h00;
      rd_addr_a = 3'd1;
      @(posedge clk);
      #1;
   endtask

   function automatic string req_of(input logic [3:0] op, input logic [2:0] rd);
      if (rd == 3'd0) return "R2";
      case (op)
         OP_LSL, OP_LSR:   return "R3";
         OP_ADDL, OP_ADDH: return "R4";
         OP_SUBL:          return "R5";
         OP_LDL, OP_LDH:   return "R6";
         default:          return "R7";
      endcase
   endfunction

   function automatic logic [127:0] line(input int k);
      return 128'd1 << k;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "pc", pc_q, 16'h0000);
      check("R1", "flags", {flag_n, flag_z, flag_v, flag_c}, 4'b0000);
      check("R1", "irq", irq_pulse, '0);
      for (int r = 0; r < 8; r++) begin
         rd_addr_a = 3'(r);
         #1;
         check("R1", "register", rd_data_a, 16'h0000);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // vector table: R2 R3 R4 R5 R6 R7 R9 R12
      for (int i = 0; i < NV; i++) begin
         run_op(VEC[i][34:31], VEC[i][30:28], VEC[i][27:20]);
         check(req_of(VEC[i][34:31], VEC[i][30:28]), "reg", rd_data_a, VEC[i][19:4]);
         check(req_of(VEC[i][34:31], VEC[i][30:28]), "flags",
               {flag_n, flag_z, flag_v, flag_c}, VEC[i][3:0]);
         check("R9", "pc", pc_q, 16'(2 * (i + 1)));
         if (i == 1 || i == 3) check("R12", "16-bit build", rd_data_a, VEC[i][19:4]);
      end

      // R8: jump-and-link (pc 0x36 on entry)
      run_op(OP_LDL, 3'd7, 8'h40);
      run_op(OP_CMPL, 3'd7, 8'h41);
      check("R7", "flags", {flag_n, flag_z, flag_v, flag_c}, 4'b1001);
      run_op(OP_JAL, 3'd7, 8'h00);
      check("R8", "pc", pc_q, 16'h0040);
      check("R8", "link", rd_data_a, 16'h003C);
      check("R8", "flags", {flag_n, flag_z, flag_v, flag_c}, 4'b1001);
      run_op(OP_JAL, 3'd0, 8'h00);
      check("R8", "pc via r0", pc_q, 16'h0000);
      check("R2", "r0 after link", rd_data_a, 16'h0000);

      // R9: idle cycle changes nothing
      idle_cycle();
      check("R9", "reg", rd_data_a, 16'h68AC);
      check("R9", "pc", pc_q, 16'h0000);
      check("R9", "flags", {flag_n, flag_z, flag_v, flag_c}, 4'b1001);

      // R11: unused opcode
      run_op(4'hF, 3'd1, 8'h55);
      check("R11", "reg", rd_data_a, 16'h68AC);
      check("R11", "pc", pc_q, 16'h0002);
      check("R11", "flags", {flag_n, flag_z, flag_v, flag_c}, 4'b1001);
      run_op(OP_NOP, 3'd1, 8'h55);
      check("R11", "nop pc", pc_q, 16'h0004);

      // R10: software triggers, back to back
      run_op(OP_LDL, 3'd3, 8'h05);
      check("R10", "irq idle", irq_pulse, '0);
      run_op(OP_SIF, 3'd3, 8'h00);
      check("R10", "irq ch5", irq_pulse, line(5));
      run_op(OP_SIF, 3'd6, 8'h00);
      check("R10", "irq ch128 ignored", irq_pulse, '0);
      run_op(OP_LDL, 3'd6, 8'h7F);
      check("R10", "irq after load", irq_pulse, '0);
      run_op(OP_SIF, 3'd6, 8'h00);
      check("R10", "irq ch127", irq_pulse, line(127));
      run_op(OP_SIF, 3'd3, 8'h00);
      check("R10", "irq ch5 follows ch127", irq_pulse, line(5));
      run_op(OP_SIF, 3'd0, 8'h00);
      check("R10", "irq ch0 via r0", irq_pulse, line(0));
      run_op(OP_SIF, 3'd1, 8'h00);
      check("R10", "irq ch172 ignored", irq_pulse, '0);
      run_op(OP_SIF, 3'd3, 8'h00);
      idle_cycle();
      check("R10", "irq one cycle only", irq_pulse, '0);

      // R2: read port B
      @(negedge clk);
      rd_addr_b = 3'd1;
      #1;
      check("R2", "port b r1", rd_data_b, 16'h68AC);
      rd_addr_b = 3'd0;
      #1;
      check("R2", "port b r0", rd_data_b, 16'h0000);

      // R1: asynchronous reset mid-run
      @(negedge clk);
      rd_addr_a = 3'd1;
      rst_n = 1'b0;
      #1;
      check("R1", "reg after reset", rd_data_a, 16'h0000);
      check("R1", "pc after reset", pc_q, 16'h0000);
      check("R1", "flags after reset", {flag_n, flag_z, flag_v, flag_c}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule